// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit carries out one single-bit operation per accepted request on a 32-bit word. The operation is test, clear, set or change (invert). A 5-bit index picks the bit. The word comes either from the request's data input or from an 8-bit status register that the unit holds itself. The result is registered, so the outputs show the outcome one clock after the request.

For a data-word target, the unit produces the edited word. It copies the bit's value from before the edit into the carry flag of the status register. For a status-register target, the unit edits the chosen flag in place. The data result and the carry flag then stay as they were. A surrounding datapath issues one request per cycle by raising `req_valid`. It then reads `word_out` and `flags` in the following cycle.

Top module: `bit_edit_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `flags` and `word_out` become all zeros after that edge.
- R2: With `to_flags` low, an accepted request writes `word_in` into `word_out` with bit `bit_sel` changed as follows: cleared for `op_code` 2'b01, set for 2'b10, inverted for 2'b11. All other bits are copied unchanged. The new value is visible one cycle after `req_valid`.
- R3: With `to_flags` low and `op_code` 2'b00 (test), `word_out` keeps its previous value.
- R4: With `to_flags` low, for every operation, `flags[0]` (carry) takes the value that bit `bit_sel` of `word_in` had before the edit. `flags[7:1]` keep their values.
- R5: With `to_flags` high and `bit_sel` below 8, the flag at position `bit_sel` is edited. The layout from bit 0 upward is C, V, Z, N, I, LR, R, A. Clear forces that flag to 0, set forces it to 1, and change inverts it. All other flags are left as they were.
- R6: With `to_flags` high, `word_out` is unchanged, and a test operation leaves `flags` unchanged.
- R7: With `to_flags` high and `bit_sel` from 8 to 31, `flags` is unchanged for every operation.
- R8: A cycle with `req_valid` low changes neither `flags` nor `word_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request accepted at this edge |
| op_code | input | 2 | 00 test, 01 clear, 10 set, 11 change |
| bit_sel | input | 5 | Bit index |
| to_flags | input | 1 | Target is the status register |
| word_in | input | 32 | Data word operand |
| word_out | output | 32 | Registered edited data word |
| flags | output | 8 | Status register: A R LR I N Z V C from bit 7 down to bit 0 |

## Verification
One data-word request updates two outputs at the same edge: it writes the edited word, and it loads the carry flag from that word's bit before the edit. The bench provokes this with clear and set requests on bits that already hold the target value, and with change requests on both bit values. It then checks that the carry flag still shows the original bit, while the word shows the edited one. Requests that target the status register are issued back to back with data-word requests, and bit 0 (the carry flag itself) is among the targets. This shows that editing C through the status register and loading C from a data word never merge. The scoreboard compares both outputs of every request against a model kept in the bench.

// File: rtl/bit_edit_unit.sv
module bit_edit_unit #(
  parameter int WORD_W = 32,
  parameter int FLAG_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [1:0]                op_code,
  input  logic [$clog2(WORD_W)-1:0] bit_sel,
  input  logic                      to_flags,
  input  logic [WORD_W-1:0]         word_in,
  output logic [WORD_W-1:0]         word_out,
  output logic [FLAG_W-1:0]         flags
);
  localparam int FIW = $clog2(FLAG_W);
  localparam logic [1:0] OP_TEST = 2'b00, OP_CLR = 2'b01, OP_SET = 2'b10, OP_CHG = 2'b11;

  logic [WORD_W-1:0] wmask, wedit;
  logic [FLAG_W-1:0] fmask, fedit;
  logic              flag_hit;

  assign wmask    = {{(WORD_W-1){1'b0}}, 1'b1} << bit_sel;
  assign flag_hit = int'(bit_sel) < FLAG_W;
  assign fmask    = flag_hit ? ({{(FLAG_W-1){1'b0}}, 1'b1} << bit_sel[FIW-1:0]) : '0;

  always_comb begin
    case (op_code)
      OP_CLR:  begin wedit = word_in & ~wmask; fedit = flags & ~fmask; end
      OP_SET:  begin wedit = word_in | wmask;  fedit = flags | fmask;  end
      OP_CHG:  begin wedit = word_in ^ wmask;  fedit = flags ^ fmask;  end
      default: begin wedit = word_out;         fedit = flags;          end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out <= '0;
      flags    <= '0;
    end else if (req_valid) begin
      if (to_flags) begin
        flags <= fedit;
      end else begin
        word_out <= wedit;
        flags[0] <= word_in[bit_sel];
      end
    end
  end
endmodule

module bit_edit_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [1:0]  op_code,
  input logic [4:0]  bit_sel,
  input logic        to_flags,
  input logic [31:0] word_in,
  input logic [31:0] word_out,
  input logic [7:0]  flags
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (flags == 8'h00 && word_out == 32'h0));

  a_r3_test_keeps_word: assert property (@(posedge clk) disable iff (rst)
    req_valid && !to_flags && op_code == 2'b00 |=> $stable(word_out));

  a_r4_carry_load: assert property (@(posedge clk) disable iff (rst)
    req_valid && !to_flags |=> flags[0] == $past(word_in[bit_sel]));

  a_r4_upper_flags_kept: assert property (@(posedge clk) disable iff (rst)
    req_valid && !to_flags |=> $stable(flags[7:1]));

  a_r5_change_flips_one: assert property (@(posedge clk) disable iff (rst)
    req_valid && to_flags && op_code == 2'b11 && bit_sel < 5'd8 |=> $countones(flags ^ $past(flags)) == 1);

  a_r6_flags_target_word_kept: assert property (@(posedge clk) disable iff (rst)
    req_valid && to_flags |=> $stable(word_out));

  a_r7_out_of_range_ignored: assert property (@(posedge clk) disable iff (rst)
    req_valid && to_flags && bit_sel >= 5'd8 |=> $stable(flags));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(flags) && $stable(word_out));
endmodule

bind bit_edit_unit bit_edit_unit_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .op_code(op_code), .bit_sel(bit_sel),
  .to_flags(to_flags), .word_in(word_in), .word_out(word_out), .flags(flags)
);

// File: tb/sim_bit_edit_unit.sv
module sim_bit_edit_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  op_code = 2'b00;
  logic [4:0]  bit_sel = 5'd0;
  logic        to_flags = 1'b0;
  logic [31:0] word_in = 32'h0;
  logic [31:0] word_out;
  logic [7:0]  flags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] w;
    logic [7:0]  f;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [31:0] m_word = 32'h0;
  logic [7:0]  m_flags = 8'h00;

  always #4 clk = ~clk;

  bit_edit_unit u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .op_code(op_code), .bit_sel(bit_sel),
    .to_flags(to_flags), .word_in(word_in), .word_out(word_out), .flags(flags)
  );

  task automatic check(input string tag, input logic [31:0] aw, input logic [7:0] af,
                       input logic [31:0] ew, input logic [7:0] ef);
    checks++;
    if (aw !== ew || af !== ef) begin
      failures++;
      $display("FAIL %s word=%h flags=%h expected word=%h flags=%h", tag, aw, af, ew, ef);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [4:0] n, input logic tf,
                       input logic [31:0] w, input string tag);
    exp_t e;
    logic [31:0] m;
    m = 32'h1 << n;
    @(negedge clk);
    req_valid = 1'b1; op_code = op; bit_sel = n; to_flags = tf; word_in = w;
    if (!tf) begin
      m_flags[0] = w[n];
      case (op)
        2'b01: m_word = w & ~m;
        2'b10: m_word = w | m;
        2'b11: m_word = w ^ m;
        default: ;
      endcase
    end else if (n < 5'd8) begin
      case (op)
        2'b01: m_flags[n[2:0]] = 1'b0;
        2'b10: m_flags[n[2:0]] = 1'b1;
        2'b11: m_flags[n[2:0]] = ~m_flags[n[2:0]];
        default: ;
      endcase
    end
    e.w = m_word; e.f = m_flags; e.tag = tag;
    @(posedge clk);
    sb.push_back(e);
  endtask

  task automatic idle(input int cycles);
    exp_t e;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      req_valid = 1'b0; word_in = ~word_in; op_code = 2'b11;
      e.w = m_word; e.f = m_flags; e.tag = "R8";
      @(posedge clk);
      sb.push_back(e);
    end
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, word_out, flags, e.w, e.f);
    end
  end

  initial begin
    string t;
    logic [31:0] pat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", word_out, flags, 32'h0, 8'h00);
    rst = 1'b0;

    for (int k = 0; k < 2; k++)
      for (int op = 0; op < 4; op++)
        for (int i = 0; i < 32; i++) begin
          pat = 32'hA5C3_1E96 ^ (32'(i) * 32'h0101_0101);
          if (k == 1) pat = ~pat;
          t = (op == 0) ? "R3/R4" : "R2/R4";
          issue(2'(op), 5'(i), 1'b0, pat, t);
        end

    for (int r = 0; r < 2; r++)
      for (int op = 0; op < 4; op++)
        for (int b = 0; b < 8; b++) begin
          t = (op == 0) ? "R6" : "R5";
          issue(2'(op), 5'(b), 1'b1, 32'hFFFF_FFFF, t);
          issue(2'b11, 5'(b), 1'b0, 32'h0000_00FF << (b * 3), "R4");
        end

    issue(2'b10, 5'd3, 1'b1, 32'h0, "R5");
    for (int n = 8; n < 32; n++) begin
      issue(2'b10, 5'(n), 1'b1, 32'hDEAD_BEEF, "R7");
      issue(2'b11, 5'(n), 1'b1, 32'h1234_5678, "R7");
    end
    idle(4);

    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", word_out, flags, 32'h0, 8'h00);
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired before the run completed");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule